// File: doc/BRIEF.md
# Vectored Interrupt Priority Resolver with Dual Service Bands

This block sits between a set of peripheral request lines and a CPU core. It turns request edges into pending flags and masks them with per-source enables and a global enable. It then picks one winner and hands the core a registered request, the winner's 16-bit service address, its source number and the service path to use. Each maskable source is steered by a route bit. With the bit clear the source goes to ordinary software service. With the bit set it goes to a hardware transfer-service path, whose whole priority band sits above every ordinary request. A nonmaskable line outranks both bands and is not gated by the global enable.

Source 0 is a shared slot fed by a group of peripheral sub-sources, each with its own pending flag and enable. A small sub-resolver inside the block reports which sub-source currently leads. When the core acknowledges source 0, only the reported sub-source is cleared, so the slot stays pending while other enabled sub-sources wait. Source 13 is permanently reserved. Elaboration parameters retire the serial-bus lines (sources 6, 7, 8) and the converter line (source 5) on variants that lack them.

The core acknowledges with a one-cycle pulse naming the serviced source (0..14, or 15 for the nonmaskable line). Asynchronous reset is synchronised internally before it is released.

Top module: `irq_vector_arbiter`

## Requirements
- R1: After reset, irq_out, xfer_out, vec_out, win_id and sub_id are all zero, and while irq_out is low vec_out is zero and xfer_out is low.
- R2: A pending flag is set only by a low-to-high transition of its request; a request held high after acknowledge does not raise a new interrupt.
- R3: An ordinary-service source n ranks n, and the higher number wins. Its service address is 0x2000 + 2·n, and xfer_out is 0.
- R4: A source n with its route bit set ranks 15 + n and beats every ordinary-service request. Its service address is 0x2040 + 2·n, and xfer_out is 1.
- R5: The nonmaskable request wins over everything, even with the global enable low. It reports win_id 15 and address 0x203E.
- R6: A maskable source raises no request while its enable bit or the global enable is low. Its pending flag is kept and wins once both enables are high again, one cycle later.
- R7: Source 13 never becomes pending or wins. With HAS_SERBUS = 0, sources 6, 7 and 8 are likewise ignored, and with HAS_CONV = 0 source 5 is ignored.
- R8: An acknowledge clears the named pending flag and drops irq_out on the next clock edge. The next winner, if any, appears one edge later.
- R9: When a new request edge and an acknowledge of the same source fall in the same cycle, the flag stays pending.
- R10: sub_id reports k+1 for the highest-indexed enabled pending sub-source k, or 0 if none. Source 0 is pending while any enabled sub-source is. Acknowledging source 0 clears only the sub-source shown on sub_id.
- R11: Outputs hold steady while the winner is unchanged and no acknowledge occurs. A higher-ranked arrival replaces them before acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gie | input | 1 | Global enable for maskable sources |
| src_en | input | 15 | Per-source enable, bit n for source n |
| src_route | input | 15 | 1 steers source n to the transfer-service band |
| src_req | input | 14 | Request lines of sources 14..1 |
| nmi_req | input | 1 | Nonmaskable request line |
| sub_req | input | NUM_SUB | Sub-source request lines of the shared slot |
| sub_en | input | NUM_SUB | Sub-source enables |
| ack | input | 1 | One-cycle acknowledge pulse |
| ack_id | input | 4 | Source being acknowledged, 15 = nonmaskable |
| irq_out | output | 1 | Request to the core |
| vec_out | output | 16 | Service address of the winner |
| xfer_out | output | 1 | 1 = transfer-service path |
| win_id | output | 4 | Winning source number, 15 = nonmaskable |
| sub_id | output | SUB_ID_W | Leading sub-source plus one, 0 = none |

## Verification
The hardest case to reach is an acknowledge and a fresh request edge on the same source landing in the same cycle. The stimulus gets there by first pulsing the line so the flag is pending, then returning it low. On the acknowledge cycle it drives both the rising request and the acknowledge together. The shared slot is driven with two sub-sources at once and acknowledged twice, so the ordering and the single-bit clear both show up on sub_id. A second instance built without the serial-bus lines runs on the same stimulus, so its tie-off can be compared against the full build.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  localparam int NUM_SRC = 15;
  localparam int ID_W    = 4;
  localparam int NMI_ID  = 15;
  localparam int RANK_W  = 5;
  localparam int RSV_SRC = 13;
  localparam logic [15:0] VEC_NORM_BASE = 16'h2000;
  localparam logic [15:0] VEC_XFER_BASE = 16'h2040;
  localparam logic [15:0] VEC_NMI       = 16'h203E;

  function automatic logic [15:0] vec_of(input logic [ID_W-1:0] id, input logic xfer);
    logic [15:0] v;
    if (id == ID_W'(NMI_ID)) v = VEC_NMI;
    else if (xfer)           v = VEC_XFER_BASE + {11'd0, id, 1'b0};
    else                     v = VEC_NORM_BASE + {11'd0, id, 1'b0};
    return v;
  endfunction
endpackage

// File: rtl/irq_edge_pend.sv
module irq_edge_pend #(
  parameter int           W   = 1,
  parameter logic [W-1:0] TIE = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] req,
  input  logic [W-1:0] clr,
  output logic [W-1:0] pend
);
  logic [W-1:0] req_d;
  logic [W-1:0] pend_q;
  logic [W-1:0] set_v;
  logic [W-1:0] pend_n;
  logic         pend_en;

  always_comb begin
    set_v   = req & ~req_d & ~TIE;
    pend_n  = (pend_q & ~clr) | set_v;   // set wins over clear
    pend_en = |(set_v | clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_d  <= '0;
      pend_q <= '0;
    end else begin
      req_d <= req;
      if (pend_en) pend_q <= pend_n;
    end
  end

  assign pend = pend_q;
endmodule

// File: rtl/irq_sub_resolver.sv
module irq_sub_resolver #(
  parameter int N         = 8,
  parameter bit MSB_FIRST = 1'b1,
  parameter int IW        = $clog2(N + 1)
) (
  input  logic [N-1:0]  pend,
  input  logic [N-1:0]  en,
  output logic          any,
  output logic [IW-1:0] id
);
  logic [N-1:0] live;
  assign live = pend & en;
  assign any  = |live;

  generate
    if (MSB_FIRST) begin : g_msb
      always_comb begin
        id = '0;
        for (int i = 0; i < N; i++)
          if (live[i]) id = IW'(i + 1);
      end
    end else begin : g_lsb
      always_comb begin
        id = '0;
        for (int i = N - 1; i >= 0; i--)
          if (live[i]) id = IW'(i + 1);
      end
    end
  endgenerate
endmodule

// File: rtl/irq_pick.sv
module irq_pick
  import irq_arb_pkg::*;
#(
  parameter int N = NUM_SRC
) (
  input  logic [N-1:0]    elig,
  input  logic [N-1:0]    route,
  input  logic            nmi,
  output logic            valid,
  output logic            xfer,
  output logic [ID_W-1:0] id,
  output logic [15:0]     vec
);
  logic [RANK_W-1:0] best_r;
  logic [RANK_W-1:0] r;

  always_comb begin
    valid  = 1'b0;
    xfer   = 1'b0;
    id     = '0;
    best_r = '0;
    r      = '0;
    for (int i = 0; i < N; i++) begin
      r = route[i] ? RANK_W'(N + i) : RANK_W'(i);
      if (elig[i] && (!valid || r > best_r)) begin
        valid  = 1'b1;
        best_r = r;
        id     = ID_W'(i);
        xfer   = route[i];
      end
    end
    if (nmi) begin
      valid = 1'b1;
      id    = ID_W'(NMI_ID);
      xfer  = 1'b0;
    end
    vec = valid ? vec_of(id, xfer) : 16'h0000;
  end
endmodule

// File: rtl/irq_vector_arbiter.sv
module irq_vector_arbiter
  import irq_arb_pkg::*;
#(
  parameter bit HAS_SERBUS    = 1'b1,
  parameter bit HAS_CONV      = 1'b1,
  parameter int NUM_SUB       = 8,
  parameter bit SUB_MSB_FIRST = 1'b1,
  parameter int SUB_ID_W      = $clog2(NUM_SUB + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                gie,
  input  logic [NUM_SRC-1:0]  src_en,
  input  logic [NUM_SRC-1:0]  src_route,
  input  logic [NUM_SRC-1:1]  src_req,
  input  logic                nmi_req,
  input  logic [NUM_SUB-1:0]  sub_req,
  input  logic [NUM_SUB-1:0]  sub_en,
  input  logic                ack,
  input  logic [ID_W-1:0]     ack_id,
  output logic                irq_out,
  output logic [15:0]         vec_out,
  output logic                xfer_out,
  output logic [ID_W-1:0]     win_id,
  output logic [SUB_ID_W-1:0] sub_id
);
  // tie-off mask over sources NUM_SRC-1..1 (bit k-1 stands for source k)
  localparam int HW = NUM_SRC - 1;
  localparam logic [HW-1:0] TIE_HI =
      (HW'(1) << (RSV_SRC - 1))
    | (HAS_SERBUS ? HW'(0) : (HW'(7) << 5))
    | (HAS_CONV   ? HW'(0) : (HW'(1) << 4));

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync;
  logic       core_rst_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign core_rst_n = rst_sync[1];

  // acknowledge decode
  logic [HW-1:0]      clr_main;
  logic               clr_nmi;
  logic [NUM_SUB-1:0] clr_sub;
  logic [SUB_ID_W-1:0] sub_q;

  always_comb begin
    for (int i = 1; i < NUM_SRC; i++)
      clr_main[i-1] = ack && (ack_id == ID_W'(i));
    clr_nmi = ack && (ack_id == ID_W'(NMI_ID));
    for (int k = 0; k < NUM_SUB; k++)
      clr_sub[k] = ack && (ack_id == '0) && (sub_q == SUB_ID_W'(k + 1));
  end

  // pending banks
  logic [HW-1:0]      main_pend;
  logic [0:0]         nmi_pend;
  logic [NUM_SUB-1:0] sub_pend;

  irq_edge_pend #(.W(HW), .TIE(TIE_HI)) u_main_pend (
    .clk(clk), .rst_n(core_rst_n), .req(src_req), .clr(clr_main), .pend(main_pend));

  irq_edge_pend #(.W(1), .TIE(1'b0)) u_nmi_pend (
    .clk(clk), .rst_n(core_rst_n), .req(nmi_req), .clr(clr_nmi), .pend(nmi_pend));

  irq_edge_pend #(.W(NUM_SUB), .TIE('0)) u_sub_pend (
    .clk(clk), .rst_n(core_rst_n), .req(sub_req), .clr(clr_sub), .pend(sub_pend));

  // shared slot sub-resolver
  logic                sub_any;
  logic [SUB_ID_W-1:0] sub_c;
  irq_sub_resolver #(.N(NUM_SUB), .MSB_FIRST(SUB_MSB_FIRST), .IW(SUB_ID_W)) u_sub (
    .pend(sub_pend), .en(sub_en), .any(sub_any), .id(sub_c));

  // arbitration
  logic [NUM_SRC-1:0] src_pend;
  logic [NUM_SRC-1:0] elig;
  assign src_pend = {main_pend, sub_any};
  assign elig     = src_pend & src_en & {NUM_SRC{gie}};

  logic            c_valid;
  logic            c_xfer;
  logic [ID_W-1:0] c_id;
  logic [15:0]     c_vec;
  irq_pick #(.N(NUM_SRC)) u_pick (
    .elig(elig), .route(src_route), .nmi(nmi_pend[0]),
    .valid(c_valid), .xfer(c_xfer), .id(c_id), .vec(c_vec));

  // output register: next state
  logic                irq_q, irq_n;
  logic                xfer_q, xfer_n;
  logic [ID_W-1:0]     id_q, id_n;
  logic [15:0]         vec_q, vec_n;
  logic [SUB_ID_W-1:0] sub_n;
  logic                out_en;

  always_comb begin
    if (ack) begin
      irq_n  = 1'b0;
      xfer_n = 1'b0;
      id_n   = '0;
      vec_n  = '0;
      sub_n  = '0;
    end else begin
      irq_n  = c_valid;
      xfer_n = c_xfer;
      id_n   = c_id;
      vec_n  = c_vec;
      sub_n  = sub_c;
    end
    out_en = (irq_n != irq_q) || (xfer_n != xfer_q) || (id_n != id_q)
          || (vec_n != vec_q) || (sub_n != sub_q);
  end

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) begin
      irq_q  <= 1'b0;
      xfer_q <= 1'b0;
      id_q   <= '0;
      vec_q  <= '0;
      sub_q  <= '0;
    end else if (out_en) begin
      irq_q  <= irq_n;
      xfer_q <= xfer_n;
      id_q   <= id_n;
      vec_q  <= vec_n;
      sub_q  <= sub_n;
    end
  end

  assign irq_out  = irq_q;
  assign xfer_out = xfer_q;
  assign win_id   = id_q;
  assign vec_out  = vec_q;
  assign sub_id   = sub_q;
endmodule

// File: rtl/irq_vector_arbiter_chk.sv
module irq_vector_arbiter_chk
  import irq_arb_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            gie,
  input logic            ack,
  input logic            irq_out,
  input logic [15:0]     vec_out,
  input logic            xfer_out,
  input logic [ID_W-1:0] win_id
);
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_out |-> (vec_out == 16'h0000 && !xfer_out));                       // R1

  AST_NORM_BAND: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_out && !xfer_out && win_id != 4'd15) |-> (vec_out[15:5] == 11'h100 && !vec_out[0])); // R3

  AST_XFER_BAND: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_out && xfer_out) |-> (vec_out[15:5] == 11'h102 && win_id != 4'd15)); // R4

  AST_NMI_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_out && win_id == 4'd15) |-> (vec_out == 16'h203E && !xfer_out));  // R5

  AST_GIE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_out && win_id != 4'd15) |-> $past(gie));                           // R6

  AST_RSV_NEVER_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> (win_id != 4'd13));                                          // R7

  AST_ACK_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !irq_out);                                                       // R8
endmodule

bind irq_vector_arbiter irq_vector_arbiter_chk chk_i (
  .clk(clk), .rst_n(rst_n), .gie(gie), .ack(ack), .irq_out(irq_out),
  .vec_out(vec_out), .xfer_out(xfer_out), .win_id(win_id));

// File: tb/irq_vector_arbiter_tb_top.sv
module irq_vector_arbiter_tb_top;
  localparam int NSUB = 8;

  logic        clk;
  logic        rst_n;
  logic        gie;
  logic [14:0] src_en;
  logic [14:0] src_route;
  logic [14:1] src_req;
  logic        nmi_req;
  logic [NSUB-1:0] sub_req;
  logic [NSUB-1:0] sub_en;
  logic        ack;
  logic [3:0]  ack_id;

  logic        irq_out, xfer_out;
  logic [15:0] vec_out;
  logic [3:0]  win_id;
  logic [3:0]  sub_id;

  logic        l_irq, l_xfer;
  logic [15:0] l_vec;
  logic [3:0]  l_id;
  logic [3:0]  l_sub;

  int n_tests;
  int n_fail;

  initial clk = 1'b0;
  always #2 clk = ~clk;   // 250 MHz

  irq_vector_arbiter #(.NUM_SUB(NSUB)) dut_i (
    .clk(clk), .rst_n(rst_n), .gie(gie), .src_en(src_en), .src_route(src_route),
    .src_req(src_req), .nmi_req(nmi_req), .sub_req(sub_req), .sub_en(sub_en),
    .ack(ack), .ack_id(ack_id), .irq_out(irq_out), .vec_out(vec_out),
    .xfer_out(xfer_out), .win_id(win_id), .sub_id(sub_id));

  irq_vector_arbiter #(.NUM_SUB(NSUB), .HAS_SERBUS(1'b0)) dut_lite_i (
    .clk(clk), .rst_n(rst_n), .gie(gie), .src_en(src_en), .src_route(src_route),
    .src_req(src_req), .nmi_req(nmi_req), .sub_req(sub_req), .sub_en(sub_en),
    .ack(ack), .ack_id(ack_id), .irq_out(l_irq), .vec_out(l_vec),
    .xfer_out(l_xfer), .win_id(l_id), .sub_id(l_sub));

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic chk_win(input string req, input logic [3:0] id, input logic [15:0] vec, input logic xf);
    chk(req, "irq_out", {31'd0, irq_out}, 32'd1);
    chk(req, "win_id", {28'd0, win_id}, {28'd0, id});
    chk(req, "vec_out", {16'd0, vec_out}, {16'd0, vec});
    chk(req, "xfer_out", {31'd0, xfer_out}, {31'd0, xf});
  endtask

  task automatic pulse_src(input int idx);
    src_req[idx] = 1'b1;
    tick(1);
    src_req[idx] = 1'b0;
  endtask

  task automatic do_ack(input logic [3:0] id);
    ack = 1'b1;
    ack_id = id;
    tick(1);
    ack = 1'b0;
    ack_id = 4'd0;
  endtask

  task automatic t_reset;
    chk("R1", "irq_out", {31'd0, irq_out}, 32'd0);
    chk("R1", "vec_out", {16'd0, vec_out}, 32'd0);
    chk("R1", "xfer/id/sub", {23'd0, xfer_out, win_id, sub_id}, 32'd0);
  endtask

  task automatic t_normal;
    pulse_src(3);
    tick(1);
    chk_win("R3", 4'd3, 16'h2006, 1'b0);
    do_ack(4'd3);
    chk("R8", "irq after ack", {31'd0, irq_out}, 32'd0);
    tick(1);
    chk("R8", "irq nothing left", {31'd0, irq_out}, 32'd0);
    src_req[2] = 1'b1; src_req[12] = 1'b1;
    tick(1);
    src_req[2] = 1'b0; src_req[12] = 1'b0;
    tick(1);
    chk_win("R3", 4'd12, 16'h2018, 1'b0);
    do_ack(4'd12);
    chk("R8", "irq drop", {31'd0, irq_out}, 32'd0);
    tick(1);
    chk_win("R8", 4'd2, 16'h2004, 1'b0);
    do_ack(4'd2);
  endtask

  task automatic t_xfer;
    src_route[1] = 1'b1;
    src_req[1] = 1'b1; src_req[14] = 1'b1;
    tick(1);
    src_req[1] = 1'b0; src_req[14] = 1'b0;
    tick(1);
    chk_win("R4", 4'd1, 16'h2042, 1'b1);
    do_ack(4'd1);
    tick(1);
    chk_win("R4", 4'd14, 16'h201C, 1'b0);
    do_ack(4'd14);
    src_route[1] = 1'b0;
  endtask

  task automatic t_nmi;
    gie = 1'b0;
    nmi_req = 1'b1; src_req[4] = 1'b1;
    tick(1);
    nmi_req = 1'b0; src_req[4] = 1'b0;
    tick(1);
    chk_win("R5", 4'd15, 16'h203E, 1'b0);
    do_ack(4'd15);
    tick(1);
    chk("R6", "gie low blocks", {31'd0, irq_out}, 32'd0);
    gie = 1'b1;
    tick(1);
    chk_win("R6", 4'd4, 16'h2008, 1'b0);
    do_ack(4'd4);
  endtask

  task automatic t_enable;
    src_en[9] = 1'b0;
    pulse_src(9);
    tick(2);
    chk("R6", "masked source", {31'd0, irq_out}, 32'd0);
    src_en[9] = 1'b1;
    tick(1);
    chk_win("R6", 4'd9, 16'h2012, 1'b0);
    do_ack(4'd9);
  endtask

  task automatic t_reserved;
    pulse_src(13);
    tick(2);
    chk("R7", "source 13 ignored", {31'd0, irq_out}, 32'd0);
    pulse_src(7);
    tick(1);
    chk_win("R7", 4'd7, 16'h200E, 1'b0);
    chk("R7", "lite build ignores 7", {31'd0, l_irq}, 32'd0);
    do_ack(4'd7);
  endtask

  task automatic t_level;
    src_req[5] = 1'b1;
    tick(2);
    chk_win("R2", 4'd5, 16'h200A, 1'b0);
    do_ack(4'd5);
    tick(2);
    chk("R2", "held level no retrigger", {31'd0, irq_out}, 32'd0);
    src_req[5] = 1'b0;
    tick(1);
  endtask

  task automatic t_set_wins;
    pulse_src(10);
    tick(1);
    chk_win("R9", 4'd10, 16'h2014, 1'b0);
    src_req[10] = 1'b1;
    do_ack(4'd10);
    src_req[10] = 1'b0;
    tick(1);
    chk_win("R9", 4'd10, 16'h2014, 1'b0);
    do_ack(4'd10);
  endtask

  task automatic t_stable;
    pulse_src(4);
    tick(1);
    chk_win("R11", 4'd4, 16'h2008, 1'b0);
    tick(3);
    chk_win("R11", 4'd4, 16'h2008, 1'b0);
    pulse_src(11);
    tick(1);
    chk_win("R11", 4'd11, 16'h2016, 1'b0);
    do_ack(4'd11);
    tick(1);
    do_ack(4'd4);
  endtask

  task automatic t_sub;
    sub_req[2] = 1'b1; sub_req[5] = 1'b1;
    tick(1);
    sub_req = '0;
    tick(1);
    chk_win("R10", 4'd0, 16'h2000, 1'b0);
    chk("R10", "sub_id top", {28'd0, sub_id}, 32'd6);
    do_ack(4'd0);
    tick(1);
    chk_win("R10", 4'd0, 16'h2000, 1'b0);
    chk("R10", "sub_id next", {28'd0, sub_id}, 32'd3);
    do_ack(4'd0);
    tick(1);
    chk("R10", "slot empty", {31'd0, irq_out}, 32'd0);
    chk("R10", "sub_id none", {28'd0, sub_id}, 32'd0);
    sub_en[1] = 1'b0;
    sub_req[1] = 1'b1;
    tick(1);
    sub_req = '0;
    tick(1);
    chk("R10", "disabled sub ignored", {28'd0, sub_id}, 32'd0);
    chk("R10", "disabled sub no irq", {31'd0, irq_out}, 32'd0);
  endtask

  initial begin
    #200000;
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    n_tests = 0; n_fail = 0;
    rst_n = 1'b0; gie = 1'b0; src_en = '0; src_route = '0; src_req = '0;
    nmi_req = 1'b0; sub_req = '0; sub_en = '0; ack = 1'b0; ack_id = 4'd0;
    tick(3);
    rst_n = 1'b1;
    tick(4);
    t_reset();
    gie = 1'b1; src_en = '1; sub_en = '1;
    tick(1);
    t_normal();
    t_xfer();
    t_nmi();
    t_enable();
    t_reserved();
    t_level();
    t_set_wins();
    t_stable();
    t_sub();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule